// File: doc/BRIEF.md
# Selectable-Architecture Shift Unit

This block is the shift unit of a small 32-bit load/store processor pipeline. It takes an operand, a 5-bit shift count and an operation code, and performs a logical left, logical right or arithmetic right shift. The issuing stage raises `start` for one cycle. The unit reports `busy` while it is still working and pulses `done` when `result` holds the answer. This lets the pipeline stall for as long as the selected implementation needs.

A build-time parameter, `IMPL`, picks one of three datapaths. All three sit behind the same port list and the same control machine.

- **Serial:** a shift register moves the operand one bit position per clock.
- **Multiplier:** the shift is done on the dedicated multiplier, which is modelled here as a behavioural multiply. A left shift by n is the low half of operand × 2^n. A right shift by n is the high half of operand × 2^(32−n).
- **Multiplexer tree:** a log-depth barrel shifter.

The control machine has three states:

- **ST_IDLE:** waiting for work.
- **ST_RUN:** a serial shift is in progress.
- **ST_DONE:** the result is valid for one cycle.

The transitions are:

- **ST_IDLE/ST_DONE → ST_RUN:** an accepted start with a non-zero count in the serial build.
- **ST_IDLE/ST_DONE → ST_DONE:** an accepted start in a barrel build, or with a zero count.
- **ST_RUN → ST_RUN:** while more than one bit position remains.
- **ST_RUN → ST_DONE:** on the last bit position.
- **ST_DONE → ST_IDLE:** when no new start arrives.

Top module: `shift_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: Operation code 2'b00 shifts left with zero fill by `amount` (0 to 31).
- R3: Operation codes 2'b01 and 2'b11 shift right with zero fill.
- R4: Operation code 2'b10 shifts right, filling vacated upper bits with bit 31 of the operand.
- R5: In the multiplier and multiplexer-tree builds, `busy` is never asserted, and `done` with the correct `result` appears on the cycle after an accepted start.
- R6: In the serial build, a start with count n > 0 makes `busy` high for n cycles, followed by `done`. A count of 0 gives `done` on the next cycle with `busy` staying low.
- R7: `done` lasts one cycle unless a new start is accepted in that cycle, and `result` holds its value while the unit is idle and no start is given.
- R8: A `start` raised while `busy` is high is ignored; the running shift keeps its operands and finishes on its original cycle.
- R9: A start is accepted in the cycle `done` is high, so shifts can issue back to back.
- R10: All three builds produce identical results for every operation code and every count, including the pass-through at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe, sampled when not busy |
| op | input | 2 | 00 left, 01/11 logical right, 10 arithmetic right |
| amount | input | 5 | Shift count |
| operand | input | 32 | Value to shift |
| result | output | 32 | Shifted value, valid while done is high |
| busy | output | 1 | Serial shift in progress |
| done | output | 1 | Result valid this cycle |

## Verification
The in-RTL properties watch the handshake on every cycle:

- the next-cycle `done` for barrel builds and zero counts;
- entry into `busy` for serial counts;
- the single-cycle `done` pulse;
- `result` holding steady while idle;
- the absence of `busy` in barrel builds.

The arithmetic is left to the directed scenarios, which run the same stimulus through all three builds at once and compare each against a reference shift:

- fill values;
- the exact count of busy cycles;
- ignoring a start issued mid-shift;
- back-to-back issue.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        SH_SLL = 2'd0,
        SH_SRL = 2'd1,
        SH_SRA = 2'd2,
        SH_RSV = 2'd3
    } shift_op_e;

    typedef enum int {
        IMPL_SERIAL = 0,
        IMPL_MULT   = 1,
        IMPL_MUX    = 2
    } impl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

endpackage

// File: rtl/shift_step1.sv
module shift_step1 #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             left,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    // One bit position per call; arithmetic fill re-uses the top bit.
    always_comb begin
        if (left)
            dout = {din[WIDTH-2:0], 1'b0};
        else
            dout = {arith & din[WIDTH-1], din[WIDTH-1:1]};
    end
endmodule

// File: rtl/shift_by_mult.sv
module shift_by_mult #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [$clog2(WIDTH)-1:0] n,
    input  logic                     left,
    input  logic                     arith,
    output logic [WIDTH-1:0]         dout
);
    localparam int AMT_W = $clog2(WIDTH);
    localparam int PW    = 2 * WIDTH + 1;

    logic             invert;
    logic [WIDTH-1:0] xin;
    logic [AMT_W:0]   k;
    logic [WIDTH:0]   pow;
    logic [PW-1:0]    prod;
    logic [WIDTH-1:0] hi;

    // Negative arithmetic right: shift the complement logically, complement back.
    assign invert = !left && arith && din[WIDTH-1];
    assign xin    = invert ? ~din : din;
    assign k      = left ? {1'b0, n} : ((AMT_W+1)'(WIDTH) - {1'b0, n});
    assign pow    = {{WIDTH{1'b0}}, 1'b1} << k;
    assign prod   = PW'(xin) * PW'(pow);
    assign hi     = prod[2*WIDTH-1:WIDTH];
    assign dout   = left ? prod[WIDTH-1:0] : (invert ? ~hi : hi);
endmodule

// File: rtl/shift_mux_tree.sv
module shift_mux_tree #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [$clog2(WIDTH)-1:0] n,
    input  logic                     left,
    input  logic                     arith,
    output logic [WIDTH-1:0]         dout
);
    localparam int AMT_W = $clog2(WIDTH);

    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stg [AMT_W+1];
    logic             fill;

    // Left shifts reuse the right-shift tree on a bit-reversed word.
    for (genvar b = 0; b < WIDTH; b++) begin : g_rev
        assign rev_in[b]  = din[WIDTH-1-b];
        assign rev_out[b] = stg[AMT_W][WIDTH-1-b];
    end

    assign fill   = !left && arith && din[WIDTH-1];
    assign stg[0] = left ? rev_in : din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = n[s] ? {{D{fill}}, stg[s][WIDTH-1:D]} : stg[s];
    end

    assign dout = left ? rev_out : stg[AMT_W];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int    WIDTH = 32,
    parameter impl_e IMPL  = IMPL_SERIAL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               op,
    input  logic [$clog2(WIDTH)-1:0] amount,
    input  logic [WIDTH-1:0]         operand,
    output logic [WIDTH-1:0]         result,
    output logic                     busy,
    output logic                     done
);
    localparam int AMT_W    = $clog2(WIDTH);
    localparam bit IS_SERIAL = (IMPL == IMPL_SERIAL);

    state_e           state_q, state_d;
    logic [WIDTH-1:0] acc_q;
    logic [AMT_W-1:0] cnt_q;
    shift_op_e        op_q;
    logic             accept;
    logic [WIDTH-1:0] barrel_res;
    logic [WIDTH-1:0] step_res;

    assign accept = start && (state_q != ST_RUN);

    // Datapath variant chosen at build time.
    if (IMPL == IMPL_MULT) begin : g_mult
        shift_by_mult #(.WIDTH(WIDTH)) core_i (
            .din(operand), .n(amount),
            .left(shift_op_e'(op) == SH_SLL), .arith(shift_op_e'(op) == SH_SRA),
            .dout(barrel_res)
        );
        assign step_res = '0;
    end else if (IMPL == IMPL_MUX) begin : g_mux
        shift_mux_tree #(.WIDTH(WIDTH)) core_i (
            .din(operand), .n(amount),
            .left(shift_op_e'(op) == SH_SLL), .arith(shift_op_e'(op) == SH_SRA),
            .dout(barrel_res)
        );
        assign step_res = '0;
    end else begin : g_serial
        shift_step1 #(.WIDTH(WIDTH)) step_i (
            .din(acc_q), .left(op_q == SH_SLL), .arith(op_q == SH_SRA),
            .dout(step_res)
        );
        assign barrel_res = '0;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start)
                    state_d = (!IS_SERIAL || amount == '0) ? ST_DONE : ST_RUN;
                else
                    state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (cnt_q == AMT_W'(1))
                    state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Operand, count and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            op_q  <= SH_SLL;
        end else if (accept) begin
            acc_q <= IS_SERIAL ? operand : barrel_res;
            cnt_q <= amount;
            op_q  <= shift_op_e'(op);
        end else if (state_q == ST_RUN) begin
            acc_q <= step_res;
            cnt_q <= cnt_q - AMT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        busy   = (state_q == ST_RUN);
        done   = (state_q == ST_DONE);
        result = acc_q;
    end

    p_quick_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!IS_SERIAL || amount == '0)) |=> done);

    p_serial_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_SERIAL && accept && amount != '0) |=> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy) |=> $stable(result));

    p_barrel_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_SERIAL && $past(start)) |-> !busy);

    p_run_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
    import shift_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_ser = 1'b0;
    logic        start_bar = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [4:0]  amount = 5'd0;
    logic [31:0] operand = 32'd0;
    logic [31:0] res_ser, res_mul, res_mux;
    logic        busy_ser, busy_mul, busy_mux;
    logic        done_ser, done_mul, done_mux;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_unit #(.WIDTH(32), .IMPL(IMPL_SERIAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_ser), .op(op), .amount(amount),
        .operand(operand), .result(res_ser), .busy(busy_ser), .done(done_ser));
    shift_unit #(.WIDTH(32), .IMPL(IMPL_MULT)) dut_mul_i (
        .clk(clk), .rst_n(rst_n), .start(start_bar), .op(op), .amount(amount),
        .operand(operand), .result(res_mul), .busy(busy_mul), .done(done_mul));
    shift_unit #(.WIDTH(32), .IMPL(IMPL_MUX)) dut_mux_i (
        .clk(clk), .rst_n(rst_n), .start(start_bar), .op(op), .amount(amount),
        .operand(operand), .result(res_mux), .busy(busy_mux), .done(done_mux));

    function automatic logic [31:0] ref_shift(logic [1:0] o, logic [4:0] n, logic [31:0] v);
        case (o)
            2'd0:    return v << n;
            2'd2:    return 32'($signed(v) >>> n);
            default: return v >> n;
        endcase
    endfunction

    function automatic string req_of(logic [1:0] o);
        case (o)
            2'd0:    return "R2";
            2'd2:    return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD_LIMIT);
            finish_run();
        end
    end

    // R1: reset values on all builds.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ser busy", 32'(busy_ser), 0);
        check("R1", "ser done", 32'(done_ser), 0);
        check("R1", "ser result", res_ser, 0);
        check("R1", "mul result", res_mul, 0);
        check("R1", "mux done", 32'(done_mux), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One shift on all three builds; checks value (R2/R3/R4, R10) and timing (R5, R6).
    task automatic t_shift(logic [1:0] o, logic [4:0] n, logic [31:0] v);
        logic [31:0] exp;
        string rq;
        exp = ref_shift(o, n, v);
        rq  = req_of(o);
        op = o; amount = n; operand = v;
        start_ser = 1'b1; start_bar = 1'b1;
        @(negedge clk);
        start_ser = 1'b0; start_bar = 1'b0;
        check("R5", "mul done", 32'(done_mul), 1);
        check("R5", "mux done", 32'(done_mux), 1);
        check("R5", "mul busy", 32'(busy_mul | busy_mux), 0);
        check(rq, "mul result (R10)", res_mul, exp);
        check(rq, "mux result (R10)", res_mux, exp);
        if (n == 0) begin
            check("R6", "ser zero-count done", 32'(done_ser), 1);
            check("R6", "ser zero-count busy", 32'(busy_ser), 0);
        end else begin
            check("R6", "ser busy first", 32'(busy_ser), 1);
            for (int i = 1; i < int'(n); i++) begin
                @(negedge clk);
                check("R6", "ser busy mid", 32'(busy_ser), 1);
            end
            @(negedge clk);
            check("R6", "ser done", 32'(done_ser), 1);
            check("R6", "ser busy end", 32'(busy_ser), 0);
        end
        check(rq, "ser result (R10)", res_ser, exp);
    endtask

    // R7: done drops and result holds while idle.
    task automatic t_hold();
        logic [31:0] exp;
        exp = ref_shift(2'd2, 5'd7, 32'hF00D_1234);
        t_shift(2'd2, 5'd7, 32'hF00D_1234);
        operand = 32'h0; amount = 5'd3; op = 2'd0;
        repeat (3) @(negedge clk);
        check("R7", "ser done low", 32'(done_ser), 0);
        check("R7", "mux done low", 32'(done_mux), 0);
        check("R7", "ser result held", res_ser, exp);
        check("R7", "mul result held", res_mul, exp);
    endtask

    // R8: start during a serial run is ignored.
    task automatic t_ignore();
        logic [31:0] exp;
        exp = ref_shift(2'd1, 5'd10, 32'hDEAD_BEEF);
        op = 2'd1; amount = 5'd10; operand = 32'hDEAD_BEEF;
        start_ser = 1'b1;
        @(negedge clk);
        start_ser = 1'b0;
        repeat (2) @(negedge clk);
        op = 2'd0; amount = 5'd1; operand = 32'h1234_5678; start_ser = 1'b1;
        @(negedge clk);
        start_ser = 1'b0;
        for (int i = 4; i < 10; i++) begin
            @(negedge clk);
            check("R8", "ser still busy", 32'(busy_ser), 1);
        end
        @(negedge clk);
        check("R8", "ser done on time", 32'(done_ser), 1);
        check("R8", "ser result unchanged", res_ser, exp);
        @(negedge clk);
    endtask

    // R9: back-to-back starts.
    task automatic t_b2b();
        op = 2'd0; amount = 5'd4; operand = 32'h0000_00FF; start_bar = 1'b1;
        @(negedge clk);
        check("R9", "mux first result", res_mux, 32'h0000_0FF0);
        amount = 5'd8; operand = 32'h0000_00AB;
        @(negedge clk);
        start_bar = 1'b0;
        check("R9", "mux done kept", 32'(done_mux), 1);
        check("R9", "mul second result", res_mul, 32'h0000_AB00);
        op = 2'd2; amount = 5'd0; operand = 32'h8000_0001; start_ser = 1'b1;
        @(negedge clk);
        check("R9", "ser zero done", 32'(done_ser), 1);
        amount = 5'd3;
        @(negedge clk);
        start_ser = 1'b0;
        check("R9", "ser accepted in done", 32'(busy_ser), 1);
        repeat (2) @(negedge clk);
        @(negedge clk);
        check("R9", "ser second result", res_ser, 32'hF000_0000);
    endtask

    // R2/R3/R4 corners and R10 sweep of every count and code.
    task automatic t_sweep();
        t_shift(2'd2, 5'd31, 32'h8000_0000);
        t_shift(2'd0, 5'd31, 32'hFFFF_FFFF);
        t_shift(2'd3, 5'd5, 32'h8000_0000);
        t_shift(2'd1, 5'd0, 32'hA5A5_5A5A);
        for (int o = 0; o < 4; o++)
            for (int n = 0; n < 32; n++)
                for (int r = 0; r < 3; r++)
                    t_shift(2'(o), 5'(n), $urandom());
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_hold();
        t_ignore();
        t_b2b();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule